// File: doc/BRIEF.md
# Atomic Multibyte Register Access Controller

This block sits on a byte-wide register bus and makes accesses to wider fields atomic. A 19-bit "wide" field spans three byte addresses and a 16-bit "pair" field spans two. Written bytes go into shadow storage. The field output changes only once every byte of that field has been written, in any order, with no access to any other address in between. Reading any byte of a field takes a snapshot of the whole live input. The remaining bytes are then served from that snapshot until all of them have been read.

Any access to another address cuts short a sequence that is in progress. The partial sequence is then discarded and a latched abort flag is set. Software clears the flag by writing 1 to it.

The top byte of the wide field is mixed. Its low 3 bits are the top of the 19-bit field and follow the atomic rules. Its upper 5 bits are plain mode bits that take effect on every write to that address.

Top module: `mbr_atomic_regs`

## Requirements
- R1: After reset, wide_q_o, pair_q_o, mode_cfg_o, abort_o and bus_rdata_o are all zero.
- R2: The wide field sits at addresses 0x10 (bits 7:0), 0x11 (bits 15:8) and 0x12 (bits 18:16 in data bits 2:0). The pair field sits at 0x20 (bits 7:0) and 0x21 (bits 15:8). A field output changes, with all of its bytes in the same clock cycle, only on the clock edge of the write that completes the set of that field's bytes. The bytes may arrive in any order.
- R3: Any access (read or write) to an address outside a field, or a read of that field, while its write sequence is partial discards the sequence. The field output is then left unchanged and abort_o becomes 1 on that edge.
- R4: A byte written twice within one sequence keeps its latest value and counts once toward completion.
- R5: After an aborted write, a new sequence on that field needs all of its bytes again. Bytes from the aborted sequence do not count.
- R6: A read whose field has no read sequence open returns the live byte and captures the whole live field. Later reads of that field's other bytes return the captured value, even if the live input has changed.
- R7: Once every byte of a field has been read, the next read of that field returns the live value again.
- R8: Any access to an address outside a field, or a write to that field, while its read sequence is partial drops the snapshot and sets abort_o.
- R9: Every write to 0x12 loads data bits 7:3 into mode_cfg_o on that edge, whether or not the field sequence completes.
- R10: A read of 0x12 returns mode_cfg_o in data bits 7:3 and field bits 18:16 in bits 2:0.
- R11: The abort flag reads as bit 0 of address 0x30. Writing 1 there clears it and writing 0 has no effect. If an abort happens in the same cycle as the clear, the flag stays set.
- R12: Read data is combinational in the cycle of the read and is zero when no read is presented. Unmapped addresses read as zero, and an access to one interrupts an open sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, same cycle |
| wide_live_i | input | 19 | Live value of the wide field |
| wide_q_o | output | 19 | Committed wide field |
| mode_cfg_o | output | 5 | Immediate mode bits from 0x12 |
| pair_live_i | input | 16 | Live value of the pair field |
| pair_q_o | output | 16 | Committed pair field |
| abort_o | output | 1 | Latched abort flag |

## Verification
Read data is due combinationally within the access cycle. Field outputs, mode bits and the abort flag are due one edge after the access that causes them. The bench drives each access just after a falling edge and compares read data 1 ns later. It compares the registered outputs at the following falling edge, after its reference model has taken the same rising edge. Live inputs are changed only between accesses, so each frozen-snapshot check compares the captured value against a live value that has since moved.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              valid;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
  } bus_req_t;

  function automatic int bytes_for(input int width);
    return (width + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/mbr_field.sv
module mbr_field
  import mbr_pkg::*;
#(
  parameter int WIDTH = 19,
  parameter int BASE  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_req_t          req_i,
  input  logic [WIDTH-1:0]  live_i,
  output logic [WIDTH-1:0]  q_o,
  output logic              hit_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              abort_o
);
  localparam int NB = bytes_for(WIDTH);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0]     wmask_q, rmask_q, sel_oh, wmask_nxt, rmask_nxt;
  logic [WIDTH-1:0]  shadow_q, shadow_nxt, snap_q, q_q, src;
  logic [ADDR_W-1:0] offset;
  logic [IW-1:0]     idx;
  logic              hit, wr_hit, rd_hit, w_done, r_done, w_abort, r_abort;

  assign offset    = req_i.addr - ADDR_W'(BASE);
  assign idx       = offset[IW-1:0];
  assign hit       = req_i.valid && (offset < ADDR_W'(NB));
  assign wr_hit    = hit && req_i.we;
  assign rd_hit    = hit && !req_i.we;
  assign sel_oh    = hit ? (NB'(1) << idx) : '0;
  assign wmask_nxt = wmask_q | sel_oh;
  assign rmask_nxt = rmask_q | sel_oh;
  assign w_done    = wr_hit && (&wmask_nxt);
  assign r_done    = rd_hit && (&rmask_nxt);
  // any other access breaks an open sequence
  assign w_abort   = req_i.valid && !wr_hit && (|wmask_q);
  assign r_abort   = req_i.valid && !rd_hit && (|rmask_q);

  always_comb begin
    shadow_nxt = shadow_q;
    for (int i = 0; i < WIDTH; i++)
      if (wr_hit && idx == IW'(i / BYTE_W)) shadow_nxt[i] = req_i.wdata[i % BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wmask_q  <= '0;
      shadow_q <= '0;
      q_q      <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (w_abort)     wmask_q <= '0;
      else if (wr_hit) wmask_q <= w_done ? '0 : wmask_nxt;
      if (w_done)      q_q <= shadow_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rmask_q <= '0;
      snap_q  <= '0;
    end else if (r_abort) begin
      rmask_q <= '0;
    end else if (rd_hit) begin
      if (rmask_q == '0) snap_q <= live_i;
      rmask_q <= r_done ? '0 : rmask_nxt;
    end
  end

  assign src = (|rmask_q) ? snap_q : live_i;

  always_comb begin
    rd_byte_o = '0;
    for (int i = 0; i < WIDTH; i++)
      if (idx == IW'(i / BYTE_W)) rd_byte_o[i % BYTE_W] = src[i];
  end

  assign q_o     = q_q;
  assign hit_o   = hit;
  assign abort_o = w_abort || r_abort;

  p_commit_needs_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_q) |-> $past(wr_hit))
    else $error("field changed without a write");
  p_abort_no_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_abort |=> $stable(q_q))
    else $error("aborted sequence committed");
  p_abort_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_abort |=> (wmask_q == '0))
    else $error("shadow kept after abort");
  p_snap_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rmask_q) |=> $stable(snap_q))
    else $error("snapshot moved during read sequence");
  p_read_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_abort |=> (rmask_q == '0))
    else $error("read sequence survived interruption");
endmodule

// File: rtl/mbr_abort_flag.sv
module mbr_abort_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q)
    else $error("abort flag not set");
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q)
    else $error("abort flag not cleared");
  p_rise_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i))
    else $error("abort flag rose without cause");
endmodule

// File: rtl/mbr_atomic_regs.sv
module mbr_atomic_regs
  import mbr_pkg::*;
#(
  parameter int WIDE_W    = 19,
  parameter int PAIR_W    = 16,
  parameter int WIDE_BASE = 16,
  parameter int PAIR_BASE = 32,
  parameter int STAT_ADDR = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic [WIDE_W-1:0] wide_live_i,
  output logic [WIDE_W-1:0] wide_q_o,
  output logic [BYTE_W-(WIDE_W-(bytes_for(WIDE_W)-1)*BYTE_W)-1:0] mode_cfg_o,
  input  logic [PAIR_W-1:0] pair_live_i,
  output logic [PAIR_W-1:0] pair_q_o,
  output logic              abort_o
);
  localparam int WIDE_NB  = bytes_for(WIDE_W);
  localparam int TOP_BITS = WIDE_W - (WIDE_NB - 1) * BYTE_W;
  localparam int CFG_W    = BYTE_W - TOP_BITS;
  localparam int MIX_ADDR = WIDE_BASE + WIDE_NB - 1;

  bus_req_t          req;
  logic              wide_hit, pair_hit, wide_ab, pair_ab, stat_hit, mix_wr, clr;
  logic [BYTE_W-1:0] wide_rd, pair_rd;
  logic [CFG_W-1:0]  cfg_q;

  assign req = '{valid: bus_valid_i, we: bus_we_i, addr: bus_addr_i, wdata: bus_wdata_i};

  mbr_field #(.WIDTH(WIDE_W), .BASE(WIDE_BASE)) u_wide (
    .clk_i, .rst_ni, .req_i(req), .live_i(wide_live_i), .q_o(wide_q_o),
    .hit_o(wide_hit), .rd_byte_o(wide_rd), .abort_o(wide_ab)
  );

  mbr_field #(.WIDTH(PAIR_W), .BASE(PAIR_BASE)) u_pair (
    .clk_i, .rst_ni, .req_i(req), .live_i(pair_live_i), .q_o(pair_q_o),
    .hit_o(pair_hit), .rd_byte_o(pair_rd), .abort_o(pair_ab)
  );

  assign stat_hit = bus_valid_i && (bus_addr_i == ADDR_W'(STAT_ADDR));
  assign clr      = stat_hit && bus_we_i && bus_wdata_i[0];
  assign mix_wr   = bus_valid_i && bus_we_i && (bus_addr_i == ADDR_W'(MIX_ADDR));

  mbr_abort_flag u_abort (
    .clk_i, .rst_ni, .set_i(wide_ab || pair_ab), .clr_i(clr), .flag_o(abort_o)
  );

  // upper bits of the mixed byte bypass the atomic path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (mix_wr) cfg_q <= bus_wdata_i[BYTE_W-1:TOP_BITS];
  end
  assign mode_cfg_o = cfg_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_we_i) begin
      if (wide_hit) begin
        bus_rdata_o = wide_rd;
        if (bus_addr_i == ADDR_W'(MIX_ADDR)) bus_rdata_o[BYTE_W-1:TOP_BITS] = cfg_q;
      end else if (pair_hit) begin
        bus_rdata_o = pair_rd;
      end else if (stat_hit) begin
        bus_rdata_o[0] = abort_o;
      end
    end
  end

  p_cfg_immediate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_wr |=> (cfg_q == $past(bus_wdata_i[BYTE_W-1:TOP_BITS])))
    else $error("mode bits not updated");
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mix_wr |=> $stable(cfg_q))
    else $error("mode bits changed without write");
  p_idle_rdata_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && !bus_we_i) |-> (bus_rdata_o == '0))
    else $error("read data without read");
endmodule

// File: tb/sim_mbr_atomic_regs.sv
`timescale 1ns/1ps
module sim_mbr_atomic_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [18:0] wide_live = '0, wide_q;
  logic [4:0]  cfg;
  logic [15:0] pair_live = '0, pair_q;
  logic        abort;

  always #2 clk = ~clk;

  mbr_atomic_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wide_live_i(wide_live), .wide_q_o(wide_q), .mode_cfg_o(cfg),
    .pair_live_i(pair_live), .pair_q_o(pair_q), .abort_o(abort)
  );

  localparam int NB[2]   = '{3, 2};
  localparam int BASE[2] = '{16, 32};
  localparam int WID[2]  = '{19, 16};

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_q[2], m_snap[2], m_sh[2][3];
  bit m_wf[2][3], m_rf[2][3];
  int m_cfg = 0, m_ab = 0;
  int last_rd;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int live_of(int f);
    return (f == 0) ? int'(wide_live) : int'(pair_live);
  endfunction

  function automatic int exp_rdata(bit v, bit w, int a);
    int r = 0;
    if (!v || w) return 0;
    for (int f = 0; f < 2; f++) begin
      if (a >= BASE[f] && a < BASE[f] + NB[f]) begin
        bit rb = 0;
        int ix = a - BASE[f];
        for (int k = 0; k < NB[f]; k++) rb |= m_rf[f][k];
        r = ((rb ? m_snap[f] : live_of(f)) >> (8 * ix)) & 255;
        if (f == 0 && ix == 2) r |= m_cfg << 3;
      end
    end
    if (a == 48) r = m_ab;
    return r;
  endfunction

  task automatic model_step(bit v, bit w, int a, int d);
    int ab = 0;
    for (int f = 0; f < 2; f++) begin
      bit hit = v && a >= BASE[f] && a < BASE[f] + NB[f];
      int ix = a - BASE[f];
      bit wb = 0, rb = 0, all;
      for (int k = 0; k < NB[f]; k++) begin wb |= m_wf[f][k]; rb |= m_rf[f][k]; end
      if (v && !(hit && w) && wb) begin
        for (int k = 0; k < 3; k++) m_wf[f][k] = 0;
        ab = 1;
      end
      if (v && !(hit && !w) && rb) begin
        for (int k = 0; k < 3; k++) m_rf[f][k] = 0;
        ab = 1; rb = 0;
      end
      if (hit && w) begin
        m_sh[f][ix] = d; m_wf[f][ix] = 1; all = 1;
        for (int k = 0; k < NB[f]; k++) all &= m_wf[f][k];
        if (all) begin
          int val = 0;
          for (int k = 0; k < NB[f]; k++) val |= m_sh[f][k] << (8 * k);
          m_q[f] = val & ((1 << WID[f]) - 1);
          for (int k = 0; k < 3; k++) m_wf[f][k] = 0;
        end
      end
      if (hit && !w) begin
        if (!rb) m_snap[f] = live_of(f);
        m_rf[f][ix] = 1; all = 1;
        for (int k = 0; k < NB[f]; k++) all &= m_rf[f][k];
        if (all) for (int k = 0; k < 3; k++) m_rf[f][k] = 0;
      end
    end
    if (v && w && a == 18) m_cfg = (d >> 3) & 31;
    if (ab) m_ab = 1;
    else if (v && w && a == 48 && (d & 1)) m_ab = 0;
  endtask

  task automatic cmp_regs();
    chk("R2", "wide_q", int'(wide_q), m_q[0]);
    chk("R3", "pair_q", int'(pair_q), m_q[1]);
    chk("R9", "mode_cfg", int'(cfg), m_cfg);
    chk("R11", "abort", int'(abort), m_ab);
  endtask

  task automatic acc(bit v, bit w, int a, int d);
    @(negedge clk);
    valid = v; we = w; addr = 8'(a); wdata = 8'(d);
    #1;
    last_rd = int'(rdata);
    chk("R6", "rdata", last_rd, exp_rdata(v, w, a));
    @(posedge clk);
    model_step(v, w, a, d);
    @(negedge clk);
    valid = 0;
    cmp_regs();
  endtask

  task automatic wr(int a, int d); acc(1, 1, a, d); endtask
  task automatic rd(int a); acc(1, 0, a, 0); endtask
  task automatic idle(); acc(0, 0, 0, 0); endtask

  initial begin
    for (int f = 0; f < 2; f++) begin
      m_q[f] = 0; m_snap[f] = 0;
      for (int k = 0; k < 3; k++) begin m_sh[f][k] = 0; m_wf[f][k] = 0; m_rf[f][k] = 0; end
    end
    #9 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1", "wide_q", int'(wide_q), 0);
    chk("R1", "pair_q", int'(pair_q), 0);
    chk("R1", "cfg", int'(cfg), 0);
    chk("R1", "abort", int'(abort), 0);
    chk("R1", "rdata", int'(rdata), 0);
    idle();
    // R2 out-of-order write, commit at the last byte only
    wr(18, 8'hAD); chk("R9", "cfg immediate", int'(cfg), 5'h15);
    wr(16, 8'h34); chk("R2", "no early commit", int'(wide_q), 0);
    wr(17, 8'h12); chk("R2", "commit", int'(wide_q), 19'h51234);
    wr(33, 8'hBE); wr(32, 8'hEF); chk("R2", "pair commit", int'(pair_q), 16'hBEEF);
    // R3 interrupted write
    wr(16, 8'h00); wr(32, 8'h00); rd(48);
    chk("R3", "wide unchanged", int'(wide_q), 19'h51234);
    chk("R3", "abort set", int'(abort), 1);
    // R11 clear
    wr(48, 0); chk("R11", "write 0 keeps", int'(abort), 1);
    wr(48, 1); chk("R11", "write 1 clears", int'(abort), 0);
    // R5 + R12 restart after abort via unmapped address
    wr(16, 8'h11); wr(17, 8'h22); wr(64, 8'h99);
    chk("R12", "unmapped aborts", int'(abort), 1);
    wr(18, 8'h03); chk("R5", "single byte no commit", int'(wide_q), 19'h51234);
    wr(16, 8'h55); wr(17, 8'h66); chk("R5", "full restart commits", int'(wide_q), 19'h36655);
    rd(64); chk("R12", "unmapped reads zero", last_rd, 0);
    wr(48, 1);
    // R4 duplicate byte
    wr(32, 8'hAA); wr(32, 8'hBB); chk("R4", "dup no commit", int'(pair_q), 16'hBEEF);
    wr(33, 8'hCC); chk("R4", "latest value", int'(pair_q), 16'hCCBB);
    // R6/R7/R10 frozen read
    wide_live = 19'h4A5B6;
    rd(17); chk("R6", "live byte1", last_rd, 8'hA5);
    wide_live = 19'h01020;
    rd(16); chk("R6", "frozen byte0", last_rd, 8'hB6);
    rd(18); chk("R10", "mixed readback", last_rd, (8'h03 & 8'hF8) | 3'h4);
    rd(16); chk("R7", "live again", last_rd, 8'h20);
    rd(17); rd(18);
    // R8 interrupted read
    pair_live = 16'h1357;
    rd(32); chk("R8", "pair low", last_rd, 8'h57);
    pair_live = 16'h9ABC;
    wr(48, 0); chk("R8", "abort set", int'(abort), 1);
    rd(33); chk("R8", "unfrozen high", last_rd, 8'h9A);
    rd(32);
    // R11 set wins over clear
    wr(16, 8'h01); wr(48, 1); chk("R11", "set wins", int'(abort), 1);
    wr(48, 1); chk("R11", "clear", int'(abort), 0);
    // R9 mode bits on every write to the mixed byte; R10 readback
    wr(18, 8'hF9); chk("R9", "cfg", int'(cfg), 5'h1F);
    rd(18); chk("R10", "mixed readback", last_rd, 8'hF8 | 3'h0);
    repeat (4) idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule